// File: doc/BRIEF.md
# Edge-Triggered Interrupt Capture Unit

This block watches four single-bit digital inputs: two lines of an isolated input port and two lines of a general input port. Each input passes through a synchroniser and then an edge detector. When an armed input makes the transition picked by its own polarity bit, a sticky flag for that input is set. A single level interrupt line to the host is high while any flag is set.

Software uses a small byte-wide register interface with three registers. The arm register enables sources one by one. The edge-select register picks a rising or falling edge for each source. The status register returns the latched flags when read. Writing to the status register clears every flag whose written bit is 1. When an interrupt arrives, the host reads the status register, writes the same value back to acknowledge the flags, and handles each source that was set.

All three registers are 4 bits wide and share one source-to-bit mapping:

| Bit | Source |
|-----|--------|
| 0 | isolated input 0 |
| 1 | isolated input 1 |
| 2 | general input 0 |
| 3 | general input 1 |

Top module: `edge_irq_unit`

## Requirements
- R1: After reset, the arm register, the edge-select register and all four flags read 0, and `irq` is low.
- R2: The arm register is read and written at byte offset 0x08. Bits 3:0 are stored and follow the mapping in the table above. Bits 7:4 read as zero.
- R3: The edge-select register is read and written at byte offset 0x0C. Bits 3:0 are stored and bits 7:4 read as zero. A 0 in a bit selects the rising edge for that source and a 1 selects the falling edge.
- R4: A read of offset 0x10 returns the flags in bits 3:0, using the mapping in the table above. Bits 7:4 read as zero.
- R5: A rising edge on an armed source whose edge-select bit is 0 sets that source's flag. The flag can be read after the third rising clock edge that follows the input change, and not before.
- R6: A falling edge on an armed source whose edge-select bit is 1 sets that source's flag. The edge of the other direction sets nothing.
- R7: An edge on a source whose arm bit is 0 sets no flag.
- R8: A write to offset 0x10 clears exactly the flags whose written bit is 1. The other flags are kept.
- R9: If a flag's edge is detected in the same cycle as a write-1 clear of that flag, the flag stays set.
- R10: `irq` is high whenever at least one flag is set. It stays high until software has cleared every set flag.
- R11: Changing an edge-select bit while the source's input is steady sets no flag.
- R12: Clearing an arm bit stops new captures for that source, but a flag that is already set stays set.
- R13: A write to any offset other than 0x08, 0x0C and 0x10 changes no register. A read of any such offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised internally. |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe. The write takes effect at the rising clock edge. |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| iso_in | input | 2 | Isolated input port bits 1:0. Asynchronous. |
| plain_in | input | 2 | General input port bits 1:0. Asynchronous. |
| irq | output | 1 | Level interrupt to the host |

## Verification
An input change is driven at a falling clock edge. The change passes through two synchroniser flops, is compared against the stored previous level, and then sets the flag. So the flag and `irq` appear after the third following rising edge. The bench samples status once after two edges, where it must still be clear, and once after three edges, where the flag must be set.

A register write takes effect at the first rising edge, and read data is combinational. Each read is therefore checked at the falling edge after that rising edge.

For the set-wins case, the clear write is timed to land on the third rising edge after the input change. That is the same cycle in which the edge is detected.

// File: rtl/eiu_pkg.sv
package eiu_pkg;
  localparam int SRC_N  = 4;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] OFS_ARM  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_EDGE = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_FLAG = 5'h10;

  typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/eiu_sync.sv
module eiu_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = d_i;
    for (int k = 1; k < STAGES; k++) begin
      stage_d[k] = stage_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/eiu_edge_det.sv
module eiu_edge_det #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] pol_i,
  output logic [WIDTH-1:0] hit_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] prev_d;

  assign prev_d = lvl_i;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= prev_d;
  end

  // A hit needs a level change, and the new level must differ from the
  // polarity bit: pol 0 -> new level 1 (rising), pol 1 -> new level 0.
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    assign hit_o[g] = (lvl_i[g] ^ prev_q[g]) & (lvl_i[g] ^ pol_i[g]);

    a_r11_no_hit_on_steady_level : assert property (
      @(posedge clk) disable iff (!rst_ni)
      $stable(lvl_i[g]) |-> !hit_o[g]
    ) else $error("R11: edge hit without level change on bit %0d", g);
  end
endmodule

// File: rtl/eiu_flags.sv
module eiu_flags #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] hit_i,
  input  logic [WIDTH-1:0] arm_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] flag_o
);
  logic [WIDTH-1:0] flag_q;
  logic [WIDTH-1:0] flag_d;
  logic [WIDTH-1:0] set_w;

  assign set_w = hit_i & arm_i;

  always_comb begin
    flag_d = (flag_q & ~clr_i) | set_w;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_chk
    a_r7_flag_needs_arm : assert property (
      @(posedge clk) disable iff (!rst_ni)
      $rose(flag_q[g]) |-> $past(arm_i[g])
    ) else $error("R7: flag %0d rose while disarmed", g);

    a_r8_clear_takes_effect : assert property (
      @(posedge clk) disable iff (!rst_ni)
      (clr_i[g] && !(hit_i[g] && arm_i[g])) |=> !flag_q[g]
    ) else $error("R8: flag %0d survived clear", g);

    a_r9_set_beats_clear : assert property (
      @(posedge clk) disable iff (!rst_ni)
      (hit_i[g] && arm_i[g]) |=> flag_q[g]
    ) else $error("R9: armed hit did not set flag %0d", g);

    a_r12_flag_sticky : assert property (
      @(posedge clk) disable iff (!rst_ni)
      (flag_q[g] && !clr_i[g]) |=> flag_q[g]
    ) else $error("R12: flag %0d dropped without clear", g);
  end
endmodule

// File: rtl/eiu_regs.sv
module eiu_regs
  import eiu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  src_vec_t          flag_i,
  output src_vec_t          arm_o,
  output src_vec_t          pol_o,
  output src_vec_t          clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PAD_W = DATA_W - SRC_N;

  src_vec_t arm_q, arm_d;
  src_vec_t pol_q, pol_d;
  logic     arm_we, pol_we, flag_we;
  logic     unused_wdata_hi;

  assign unused_wdata_hi = ^wdata_i[DATA_W-1:SRC_N];

  assign arm_we  = wr_i && (addr_i == OFS_ARM);
  assign pol_we  = wr_i && (addr_i == OFS_EDGE);
  assign flag_we = wr_i && (addr_i == OFS_FLAG);

  always_comb begin
    arm_d = arm_q;
    pol_d = pol_q;
    if (arm_we) arm_d = wdata_i[SRC_N-1:0];
    if (pol_we) pol_d = wdata_i[SRC_N-1:0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= '0;
      pol_q <= '0;
    end else begin
      arm_q <= arm_d;
      pol_q <= pol_d;
    end
  end

  assign clr_o = flag_we ? wdata_i[SRC_N-1:0] : '0;
  assign arm_o = arm_q;
  assign pol_o = pol_q;

  always_comb begin
    unique case (addr_i)
      OFS_ARM:  rdata_o = {{PAD_W{1'b0}}, arm_q};
      OFS_EDGE: rdata_o = {{PAD_W{1'b0}}, pol_q};
      OFS_FLAG: rdata_o = {{PAD_W{1'b0}}, flag_i};
      default:  rdata_o = '0;
    endcase
  end

  a_r2_arm_write_lands : assert property (
    @(posedge clk) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_ARM) |=> (arm_o == $past(wdata_i[SRC_N-1:0]))
  ) else $error("R2: arm register did not take write data");

  a_r3_edge_write_lands : assert property (
    @(posedge clk) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_EDGE) |=> (pol_o == $past(wdata_i[SRC_N-1:0]))
  ) else $error("R3: edge register did not take write data");

  a_r13_stray_write_ignored : assert property (
    @(posedge clk) disable iff (!rst_ni)
    (wr_i && addr_i != OFS_ARM && addr_i != OFS_EDGE) |=> ($stable(arm_o) && $stable(pol_o))
  ) else $error("R13: unmapped write changed a register");
endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
  import eiu_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        iso_in,
  input  logic [1:0]        plain_in,
  output logic              irq
);
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic [RST_STAGES-1:0] rst_pipe_d;
  logic                  rst_int_n;

  assign rst_pipe_d = {rst_pipe_q[RST_STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= rst_pipe_d;
  end

  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  src_vec_t src_raw, src_sync, hit, arm, pol, clr, flags;

  // bit 0 iso 0, bit 1 iso 1, bit 2 plain 0, bit 3 plain 1
  assign src_raw = {plain_in[1], plain_in[0], iso_in[1], iso_in[0]};

  eiu_sync #(.WIDTH(SRC_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_ni(rst_int_n), .d_i(src_raw), .q_o(src_sync)
  );

  eiu_edge_det #(.WIDTH(SRC_N)) u_edge (
    .clk(clk), .rst_ni(rst_int_n), .lvl_i(src_sync), .pol_i(pol), .hit_o(hit)
  );

  eiu_flags #(.WIDTH(SRC_N)) u_flags (
    .clk(clk), .rst_ni(rst_int_n), .hit_i(hit), .arm_i(arm),
    .clr_i(clr), .flag_o(flags)
  );

  eiu_regs u_regs (
    .clk(clk), .rst_ni(rst_int_n), .addr_i(bus_addr), .wr_i(bus_wr),
    .wdata_i(bus_wdata), .flag_i(flags), .arm_o(arm), .pol_o(pol),
    .clr_o(clr), .rdata_o(bus_rdata)
  );

  assign irq = |flags;

  a_r10_irq_follows_flags : assert property (
    @(posedge clk) disable iff (!rst_int_n)
    ($countones(flags) != 0) |-> irq
  ) else $error("R10: flag set but irq low");

  a_r1_quiet_after_reset : assert property (
    @(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (!irq && arm == '0 && pol == '0)
  ) else $error("R1: state not clean on reset release");
endmodule

// File: tb/edge_irq_unit_test.sv
`timescale 1ns/1ps
module edge_irq_unit_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [1:0] iso_in;
  logic [1:0] plain_in;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  edge_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .iso_in(iso_in),
    .plain_in(plain_in), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
    bus_addr = a;
    #0.5;
    chk(req, bus_rdata, exp);
  endtask

  // input change at a falling edge, result due after the third rising edge
  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rd_chk("R1 arm", 5'h08, 8'h00);
    rd_chk("R1 edge", 5'h0C, 8'h00);
    rd_chk("R1 flags", 5'h10, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_regs();
    wr(5'h08, 8'hFF); rd_chk("R2 arm readback", 5'h08, 8'h0F);
    wr(5'h0C, 8'hA5); rd_chk("R3 edge readback", 5'h0C, 8'h05);
    wr(5'h14, 8'hFF);
    rd_chk("R13 stray read", 5'h14, 8'h00);
    rd_chk("R13 arm kept", 5'h08, 8'h0F);
    rd_chk("R13 edge kept", 5'h0C, 8'h05);
    wr(5'h08, 8'h00); wr(5'h0C, 8'h00);
  endtask

  task automatic t_disarmed();
    @(negedge clk); iso_in[0] = 1'b1;
    settle();
    rd_chk("R7 disarmed edge", 5'h10, 8'h00);
    @(negedge clk); iso_in[0] = 1'b0;
    settle();
  endtask

  task automatic t_rising();
    wr(5'h08, 8'h0F);
    @(negedge clk); plain_in[0] = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    rd_chk("R5 not yet after two edges", 5'h10, 8'h00);
    @(posedge clk); @(negedge clk);
    rd_chk("R5 R4 plain0 at bit2", 5'h10, 8'h04);
    chk("R10 irq up", {7'd0, irq}, 8'h01);
    wr(5'h10, 8'h04);
    rd_chk("R8 cleared", 5'h10, 8'h00);
    chk("R10 irq down", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_falling();
    wr(5'h0C, 8'h02);
    @(negedge clk); iso_in[1] = 1'b1;
    settle();
    rd_chk("R6 wrong direction ignored", 5'h10, 8'h00);
    @(negedge clk); iso_in[1] = 1'b0;
    settle();
    rd_chk("R6 R4 iso1 at bit1", 5'h10, 8'h02);
  endtask

  task automatic t_partial_clear();
    @(negedge clk); iso_in[0] = 1'b1;
    settle();
    rd_chk("R4 iso0 at bit0", 5'h10, 8'h03);
    wr(5'h10, 8'h01);
    rd_chk("R8 partial clear", 5'h10, 8'h02);
    chk("R10 irq held", {7'd0, irq}, 8'h01);
    wr(5'h10, 8'h02);
    chk("R10 irq released", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_polarity();
    wr(5'h0C, 8'h0F); wr(5'h0C, 8'h00); wr(5'h0C, 8'h0F);
    settle();
    rd_chk("R11 no flag on polarity change", 5'h10, 8'h00);
    wr(5'h0C, 8'h00);
    settle();
    rd_chk("R11 still none", 5'h10, 8'h00);
  endtask

  task automatic t_disarm_keeps();
    @(negedge clk); plain_in[1] = 1'b1;
    settle();
    rd_chk("R12 flag captured", 5'h10, 8'h08);
    wr(5'h08, 8'h07);
    @(negedge clk); plain_in[1] = 1'b0;
    settle();
    @(negedge clk); plain_in[1] = 1'b1;
    settle();
    rd_chk("R12 flag kept, no new capture", 5'h10, 8'h08);
    wr(5'h10, 8'h08);
    @(negedge clk); plain_in[1] = 1'b0;
    settle();
    rd_chk("R12 R7 disarmed after clear", 5'h10, 8'h00);
    wr(5'h08, 8'h0F);
  endtask

  task automatic t_set_wins();
    wr(5'h0C, 8'h04);
    @(negedge clk); plain_in[0] = 1'b0;
    settle();
    rd_chk("R6 plain0 falling", 5'h10, 8'h04);
    wr(5'h0C, 8'h00);
    @(negedge clk); plain_in[0] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    bus_addr = 5'h10; bus_wdata = 8'h04; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk); bus_wr = 1'b0;
    rd_chk("R9 set beats clear", 5'h10, 8'h04);
    wr(5'h10, 8'h04);
    rd_chk("R9 later clear works", 5'h10, 8'h00);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    iso_in = '0; plain_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_regs();
    t_disarmed();
    t_rising();
    t_falling();
    t_partial_clear();
    t_polarity();
    t_disarm_keeps();
    t_set_wins();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule